// File: doc/BRIEF.md
# Flash Embedded-Operation Status Generator

This block produces the status byte that a parallel NOR-style flash array presents on reads while an internal program or erase sequence is running. The current operating mode is supplied by the surrounding command logic: idle, program, erase, erase-suspended read or erase-suspended program. The same logic supplies the address and data byte being programmed and a mask that marks the sectors selected for erase. Each rising edge of the read strobe yields one registered read byte. That byte carries a data-polling bit, a toggle bit and a sector-toggle bit, or the array data when no status applies.

The two toggle bits are held in flip-flops. A flip-flop inverts only on a read whose mode and address meet its toggle condition. Both flip-flops are cleared when a new operation is started. The sector of an address is taken from its top `SECT_W` bits. The erase mask has one bit per sector, and bit n stands for sector n.

Top module: `flash_status_gen`

## Requirements
- R1: After reset, `rd_data_o` is 8'h00 and both toggle flip-flops are 0, so the first status read shows bit 6 = 0 and any toggling bit 2 = 0.
- R2: In idle mode (`mode_i` = 0), a read returns `array_data_i` unchanged and leaves both toggle flip-flops as they were.
- R3: In program mode (`mode_i` = 1), bit 7 is the inverse of `prog_data_i[7]`, bit 2 is 1, and bit 6 takes the values 0,1,0,... on successive reads after a start.
- R4: In erase mode (`mode_i` = 2), bit 7 is 0 and bit 6 alternates on every read from any address.
- R5: In erase mode, the bit-2 flip-flop inverts only on reads whose sector is set in `erase_mask_i`. A read from any other sector returns its held value without changing it.
- R6: In erase-suspended read mode (`mode_i` = 3), a read from a masked sector returns bit 7 = 1 and bit 6 = 1 with bit 2 toggling, and the bit-6 flip-flop is unchanged.
- R7: In erase-suspended read mode, a read from an unmasked sector returns `array_data_i` and changes neither flip-flop.
- R8: In erase-suspended program mode (`mode_i` = 4), bit 7 is the inverse of `prog_data_i[7]` and bit 6 toggles on every read from any address.
- R9: In erase-suspended program mode, a read at `prog_addr_i` gives bit 2 = 1 without flipping. A read from a masked sector toggles bit 2. A read from any other sector gives bit 2 = 1.
- R10: Whenever a status byte is returned, bits 5, 4, 3, 1 and 0 are 0.
- R11: `op_start_i` clears both toggle flip-flops. A read in the same cycle returns both toggle values as 0 and flips nothing.
- R12: One read is one rising edge of `rd_i`. Holding `rd_i` high for several cycles updates `rd_data_o` and the flip-flops only once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| mode_i | input | 3 | Operating mode: 0 idle, 1 program, 2 erase, 3 suspended read, 4 suspended program |
| op_start_i | input | 1 | Start-of-operation pulse, clears the toggle flip-flops |
| rd_i | input | 1 | Read strobe; its rising edge is one access |
| rd_addr_i | input | ADDR_W | Address of the read |
| prog_addr_i | input | ADDR_W | Address being programmed |
| prog_data_i | input | 8 | Data byte being programmed |
| erase_mask_i | input | 2**SECT_W | Sectors selected for erase |
| array_data_i | input | 8 | Array content at the read address |
| rd_data_o | output | 8 | Read byte, updated one clock after the read edge |

## Verification
An operation start and a read edge can fall in the same cycle. Each toggle flip-flop then sees a clear and a flip request together. The bench raises `op_start_i` on the clock where `rd_i` rises after several toggling reads have left the flip-flops at 1. It expects that read to show zero toggles and the next read to still show zero. That second result proves the flip was dropped and not applied after the clear.

// File: rtl/fsg_pkg.sv
package fsg_pkg;
  typedef enum logic [2:0] {
    MODE_IDLE      = 3'd0,
    MODE_PROG      = 3'd1,
    MODE_ERASE     = 3'd2,
    MODE_SUSP_READ = 3'd3,
    MODE_SUSP_PROG = 3'd4
  } fsg_mode_e;

  localparam int unsigned DATA_W    = 8;
  localparam int unsigned NUM_TGL   = 2;
  localparam int unsigned TGL_DATA  = 0;  // drives bit 6
  localparam int unsigned TGL_SECT  = 1;  // drives bit 2
  localparam int unsigned POLL_BIT  = 7;
  localparam int unsigned DTGL_BIT  = 6;
  localparam int unsigned STGL_BIT  = 2;
endpackage

// File: rtl/fsg_read_edge.sv
module fsg_read_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rd_i,
  output logic edge_o
);
  logic rd_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rd_q <= 1'b0;
    else         rd_q <= rd_i;
  end

  assign edge_o = rd_i & ~rd_q;

  a_r12_single_edge: assert property (@(posedge clk_i) disable iff (!rst_ni)
    edge_o |=> !edge_o);
endmodule

// File: rtl/fsg_hit_decode.sv
module fsg_hit_decode #(
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned SECT_W = 3,
  localparam int unsigned NUM_SECT = 1 << SECT_W
) (
  input  logic [ADDR_W-1:0]   rd_addr_i,
  input  logic [ADDR_W-1:0]   prog_addr_i,
  input  logic [NUM_SECT-1:0] erase_mask_i,
  output logic                sect_hit_o,
  output logic                prog_hit_o
);
  logic [SECT_W-1:0] sect_idx;

  assign sect_idx   = rd_addr_i[ADDR_W-1 -: SECT_W];
  assign sect_hit_o = erase_mask_i[sect_idx];
  assign prog_hit_o = (rd_addr_i == prog_addr_i);
endmodule

// File: rtl/fsg_toggle_bank.sv
module fsg_toggle_bank #(
  parameter int unsigned N = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic [N-1:0] flip_i,
  output logic [N-1:0] tgl_q_o,
  output logic [N-1:0] tgl_eff_o
);
  for (genvar g = 0; g < N; g++) begin : g_tgl
    logic q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     q <= 1'b0;
      else if (clr_i)  q <= 1'b0;
      else if (flip_i[g]) q <= ~q;
    end
    assign tgl_q_o[g]   = q;
    assign tgl_eff_o[g] = clr_i ? 1'b0 : q;
  end

  a_r11_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (tgl_q_o == '0));
  a_r12_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && flip_i == '0) |=> $stable(tgl_q_o));
endmodule

// File: rtl/fsg_status_mux.sv
module fsg_status_mux
  import fsg_pkg::*;
(
  input  fsg_mode_e           mode_i,
  input  logic                sect_hit_i,
  input  logic                prog_hit_i,
  input  logic                prog_msb_i,
  input  logic [NUM_TGL-1:0]  tgl_i,
  input  logic [DATA_W-1:0]   array_data_i,
  output logic [NUM_TGL-1:0]  cond_o,
  output logic                stat_sel_o,
  output logic [DATA_W-1:0]   data_o
);
  logic [DATA_W-1:0] stat;

  always_comb begin
    stat       = '0;
    cond_o     = '0;
    stat_sel_o = 1'b1;
    unique case (mode_i)
      MODE_PROG: begin
        stat[POLL_BIT]   = ~prog_msb_i;
        stat[DTGL_BIT]   = tgl_i[TGL_DATA];
        stat[STGL_BIT]   = 1'b1;
        cond_o[TGL_DATA] = 1'b1;
      end
      MODE_ERASE: begin
        stat[DTGL_BIT]   = tgl_i[TGL_DATA];
        stat[STGL_BIT]   = tgl_i[TGL_SECT];
        cond_o[TGL_DATA] = 1'b1;
        cond_o[TGL_SECT] = sect_hit_i;
      end
      MODE_SUSP_READ: begin
        if (sect_hit_i) begin
          stat[POLL_BIT]   = 1'b1;
          stat[DTGL_BIT]   = 1'b1;
          stat[STGL_BIT]   = tgl_i[TGL_SECT];
          cond_o[TGL_SECT] = 1'b1;
        end else begin
          stat_sel_o = 1'b0;
        end
      end
      MODE_SUSP_PROG: begin
        stat[POLL_BIT]   = ~prog_msb_i;
        stat[DTGL_BIT]   = tgl_i[TGL_DATA];
        cond_o[TGL_DATA] = 1'b1;
        if (!prog_hit_i && sect_hit_i) begin
          stat[STGL_BIT]   = tgl_i[TGL_SECT];
          cond_o[TGL_SECT] = 1'b1;
        end else begin
          stat[STGL_BIT]   = 1'b1;
        end
      end
      default: stat_sel_o = 1'b0;
    endcase
    data_o = stat_sel_o ? stat : array_data_i;
  end
endmodule

// File: rtl/flash_status_gen.sv
module flash_status_gen
  import fsg_pkg::*;
#(
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned SECT_W = 3,
  localparam int unsigned NUM_SECT = 1 << SECT_W
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [2:0]          mode_i,
  input  logic                op_start_i,
  input  logic                rd_i,
  input  logic [ADDR_W-1:0]   rd_addr_i,
  input  logic [ADDR_W-1:0]   prog_addr_i,
  input  logic [7:0]          prog_data_i,
  input  logic [NUM_SECT-1:0] erase_mask_i,
  input  logic [7:0]          array_data_i,
  output logic [7:0]          rd_data_o
);
  fsg_mode_e          mode;
  logic               rd_edge;
  logic               sect_hit, prog_hit, stat_sel;
  logic [NUM_TGL-1:0] cond, flip, tgl_q, tgl_eff;
  logic [DATA_W-1:0]  rd_data_d;

  assign mode = fsg_mode_e'(mode_i);

  fsg_read_edge i_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rd_i   (rd_i),
    .edge_o (rd_edge)
  );

  fsg_hit_decode #(.ADDR_W(ADDR_W), .SECT_W(SECT_W)) i_hit (
    .rd_addr_i    (rd_addr_i),
    .prog_addr_i  (prog_addr_i),
    .erase_mask_i (erase_mask_i),
    .sect_hit_o   (sect_hit),
    .prog_hit_o   (prog_hit)
  );

  assign flip = rd_edge ? cond : '0;

  fsg_toggle_bank #(.N(NUM_TGL)) i_tgl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_i     (op_start_i),
    .flip_i    (flip),
    .tgl_q_o   (tgl_q),
    .tgl_eff_o (tgl_eff)
  );

  fsg_status_mux i_mux (
    .mode_i       (mode),
    .sect_hit_i   (sect_hit),
    .prog_hit_i   (prog_hit),
    .prog_msb_i   (prog_data_i[7]),
    .tgl_i        (tgl_eff),
    .array_data_i (array_data_i),
    .cond_o       (cond),
    .stat_sel_o   (stat_sel),
    .data_o       (rd_data_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      rd_data_o <= '0;
    else if (rd_edge) rd_data_o <= rd_data_d;
  end

  a_r10_spare_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_edge && stat_sel) |=> ((rd_data_o & 8'h3B) == 8'h00));
  a_r4_erase_poll: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_edge && mode == MODE_ERASE) |=> !rd_data_o[7]);
  a_r2_idle_pass: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_edge && mode == MODE_IDLE) |=> (rd_data_o == $past(array_data_i)));
  a_r12_no_edge_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_edge |=> $stable(rd_data_o));
endmodule

// File: tb/test_flash_status_gen.sv
module test_flash_status_gen;
  localparam int ADDR_W = 12;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [2:0]  mode_i = 3'd0;
  logic        op_start_i = 1'b0;
  logic        rd_i = 1'b0;
  logic [11:0] rd_addr_i = '0;
  logic [11:0] prog_addr_i = '0;
  logic [7:0]  prog_data_i = '0;
  logic [7:0]  erase_mask_i = '0;
  logic [7:0]  array_data_i = '0;
  logic [7:0]  rd_data_o;

  int n_run = 0, n_fail = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];
  bit m6 = 0, m2 = 0;   // bench model of toggle state

  always #5 clk_i = ~clk_i;

  flash_status_gen #(.ADDR_W(ADDR_W), .SECT_W(3)) i_flash_status_gen (.*);

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  function automatic logic [7:0] model(logic [11:0] a, bit start);
    bit sh = erase_mask_i[a[11:9]];
    bit ph = (a == prog_addr_i);
    bit t6 = start ? 1'b0 : m6;
    bit t2 = start ? 1'b0 : m2;
    bit f6 = 0, f2 = 0;
    logic [7:0] e;
    case (mode_i)
      3'd1: begin e = {~prog_data_i[7], t6, 3'b0, 1'b1, 2'b0}; f6 = 1; end
      3'd2: begin e = {1'b0, t6, 3'b0, t2, 2'b0}; f6 = 1; f2 = sh; end
      3'd3: if (sh) begin e = {2'b11, 3'b0, t2, 2'b0}; f2 = 1; end
            else e = array_data_i;
      3'd4: begin
        f6 = 1; f2 = !ph && sh;
        e = {~prog_data_i[7], t6, 3'b0, f2 ? t2 : 1'b1, 2'b0};
      end
      default: e = array_data_i;
    endcase
    m6 = start ? 1'b0 : m6 ^ f6;
    m2 = start ? 1'b0 : m2 ^ f2;
    return e;
  endfunction

  // driver: one read access, optional start in the same cycle, optional extra high cycles
  task automatic do_read(logic [11:0] a, string tag, bit start = 0, int hold = 0);
    @(negedge clk_i);
    rd_addr_i = a; rd_i = 1'b1; op_start_i = start;
    exp_q.push_back(model(a, start));
    tag_q.push_back(tag);
    @(negedge clk_i);
    op_start_i = 1'b0;
    repeat (hold) @(negedge clk_i);
    rd_i = 1'b0;
  endtask

  task automatic start_op(logic [2:0] m);
    @(negedge clk_i);
    mode_i = m; op_start_i = 1'b1;
    m6 = 0; m2 = 0;
    @(negedge clk_i);
    op_start_i = 1'b0;
  endtask

  // monitor
  initial begin
    bit prev = 0, fire;
    forever begin
      @(posedge clk_i);
      fire = rd_i && !prev && rst_ni;
      prev = rd_i;
      @(negedge clk_i);
      if (fire) begin
        if (exp_q.size() == 0) chk("R12 unexpected result", rd_data_o, 8'hxx);
        else chk(tag_q.pop_front(), rd_data_o, exp_q.pop_front());
      end
    end
  end

  initial begin
    #1_000_000;
    n_run++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk_i);
    chk("R1 reset value", rd_data_o, 8'h00);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R1 after release", rd_data_o, 8'h00);

    array_data_i = 8'hA5;
    do_read(12'h123, "R2 idle pass");
    array_data_i = 8'h5A;
    do_read(12'h800, "R2 idle pass 2");

    prog_addr_i = 12'h010; prog_data_i = 8'h80;
    start_op(3'd1);
    do_read(12'h010, "R3 prog read1");
    do_read(12'h010, "R3 prog read2");
    do_read(12'h300, "R3 prog read3");
    prog_data_i = 8'h3F;
    do_read(12'h010, "R3 prog poll inverse");
    do_read(12'h010, "R10 prog spare bits");

    erase_mask_i = 8'b0000_0100;
    start_op(3'd2);
    do_read(12'h400, "R4 erase in sector");
    do_read(12'h400, "R5 erase in sector");
    do_read(12'hA00, "R5 erase outside hold");
    do_read(12'hA00, "R4 erase outside");
    do_read(12'h5FF, "R5 erase in sector edge");
    do_read(12'h400, "R11 start with read", 1);
    do_read(12'h400, "R11 after start");
    do_read(12'h400, "R12 held strobe", 0, 3);
    do_read(12'h400, "R12 after held strobe");

    array_data_i = 8'h3C;
    mode_i = 3'd3;
    do_read(12'h400, "R6 susp read in sector");
    do_read(12'h400, "R6 susp read again");
    do_read(12'hA00, "R7 susp read other");
    do_read(12'h400, "R7 toggles unchanged");

    mode_i = 3'd4; prog_addr_i = 12'h010; prog_data_i = 8'h00;
    do_read(12'h010, "R9 susp prog byte");
    do_read(12'h400, "R9 susp prog sector");
    do_read(12'h400, "R9 susp prog sector 2");
    do_read(12'hA00, "R9 susp prog other");
    do_read(12'h010, "R8 susp prog any addr");
    prog_data_i = 8'hFF;
    do_read(12'hA00, "R8 susp prog poll");

    array_data_i = 8'hC3;
    mode_i = 3'd0;
    do_read(12'h400, "R2 back to idle");

    repeat (4) @(negedge clk_i);
    n_run++;
    if (exp_q.size() != 0) begin
      n_fail++;
      $display("FAIL R12: got %0d pending expected 0", exp_q.size());
    end
    finish_run();
  end
endmodule